// File: doc/BRIEF.md
# UART Command Frame Parser

This block sits between a byte-wide UART receiver and a register file. It watches the received byte stream for a two-byte start marker and then reads a 16-bit address. After that it assembles one or more 32-bit data words and hands each finished word, together with the address, to a valid/ready write port. Both the address and the data arrive least significant byte first.

After the last word of a transaction, a mandatory quiet gap must pass before another transaction is accepted. The gap length is set in UART bit times. The bit time is given as a clock-tick divisor, so any rate from slow serial links up to several megabits per second can be used. A start marker that arrives during the gap is dropped, and a one-cycle error pulse reports it.

A separate splitter runs on the reply path. It takes a 32-bit result word and hands it to the UART transmitter as four bytes, least significant byte first.

Top module: `ucf_top`

## Requirements
- R1: A transaction starts only after byte 0x55 followed directly by byte 0xAA. No write is produced from bytes that do not follow such a marker.
- R2: The two bytes after the marker form the 16-bit write address, low byte first.
- R3: Each group of four following bytes forms one 32-bit write word, least significant byte first. For example, bytes 0x78, 0x56, 0x34, 0x12 give 0x12345678.
- R4: A transaction carries `word_count` words, all with the same address. A `word_count` of 0 is treated as 1.
- R5: Any byte other than 0xAA in the second marker position sends the parser back to hunting for a marker. A 0x55 in that position instead keeps the match armed, waiting for 0xAA.
- R6: After the final byte of a transaction, a 0x55 that arrives within `gap_bits` × `baud_div` clock cycles is ignored and raises `gap_err` for one cycle. Once that window has passed, a marker is accepted.
- R7: A `gap_bits` of 0 selects the default gap of 32 bit times, the length of one data word.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R9: The splitter takes a word when `res_valid` and `res_ready` are both high. It presents the word on `tx_data` as four bytes, least significant first, advancing only when `tx_ready` is high. `res_ready` stays low until the last byte has been taken.
- R10: After reset, `wr_valid`, `tx_valid` and `gap_err` are 0 and `res_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_div | input | 16 | Clock ticks per UART bit |
| gap_bits | input | 8 | Quiet gap length in bit times (0 selects 32) |
| word_count | input | 4 | Data words per transaction (0 treated as 1) |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Write word accepted |
| wr_addr | output | 16 | Write address |
| wr_data | output | 32 | Write data |
| gap_err | output | 1 | Pulse: marker dropped inside the quiet gap |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | Splitter can take a result word |
| res_data | input | 32 | Result word |
| tx_valid | output | 1 | Byte available for the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Byte to transmit |

## Verification
The hardest case to reach from the ports is the quiet gap. It opens only once a complete transaction has ended, and its length is a product of two inputs. The stimulus therefore finishes a full frame and then places a marker at a chosen cycle distance inside the window. It then places another marker beyond the window, once with an explicit gap length and once with the default. The multi-word and marker-restart cases are driven as directed byte sequences, and a table drives the single-word frames.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
  localparam logic [7:0] MARK_FIRST  = 8'h55;
  localparam logic [7:0] MARK_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    S_HUNT,
    S_MARK,
    S_ADDR,
    S_DATA
  } parse_state_t;
endpackage

// File: rtl/ucf_gap_timer.sv
module ucf_gap_timer #(
  parameter int DIV_W    = 16,
  parameter int GAP_W    = 8,
  parameter int DEF_BITS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [GAP_W-1:0] gap_bits,
  output logic             busy
);
  logic [DIV_W-1:0] tick_q;
  logic [GAP_W-1:0] bits_q;
  logic [GAP_W-1:0] eff_bits;
  logic [DIV_W:0]   tick_inc;
  logic             tick_end;
  logic             bit_end;

  assign eff_bits = (gap_bits == '0) ? GAP_W'(DEF_BITS) : gap_bits;
  assign tick_inc = {1'b0, tick_q} + 1'b1;
  assign tick_end = tick_inc >= {1'b0, baud_div};
  assign bit_end  = bits_q == (eff_bits - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tick_q <= '0;
      bits_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      tick_q <= '0;
      bits_q <= '0;
    end else if (busy) begin
      if (tick_end) begin
        tick_q <= '0;
        if (bit_end) busy <= 1'b0;
        else         bits_q <= bits_q + 1'b1;
      end else begin
        tick_q <= tick_inc[DIV_W-1:0];
      end
    end
  end

  // R6
  restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/ucf_frame_rx.sv
module ucf_frame_rx
  import ucf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              gap_busy,
  output logic              gap_start,
  output logic              gap_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int DBYTES = DATA_W / 8;
  localparam int ABYTES = ADDR_W / 8;
  localparam int MAXB   = (DBYTES > ABYTES) ? DBYTES : ABYTES;
  localparam int IDX_W  = $clog2(MAXB) + 1;
  localparam logic [IDX_W-1:0] A_LAST = IDX_W'(ABYTES - 1);
  localparam logic [IDX_W-1:0] D_LAST = IDX_W'(DBYTES - 1);

  parse_state_t      st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  widx_q;
  logic [CNT_W-1:0]  words_last;
  logic [DATA_W-1:0] asm_q;
  logic [ADDR_W-1:0] addr_q;

  assign words_last = (word_count == '0) ? '0 : word_count - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_HUNT;
      idx_q     <= '0;
      widx_q    <= '0;
      asm_q     <= '0;
      addr_q    <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      gap_start <= 1'b0;
      gap_err   <= 1'b0;
    end else begin
      gap_start <= 1'b0;
      gap_err   <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rx_valid) begin
        case (st_q)
          S_HUNT: begin
            if (rx_data == MARK_FIRST) begin
              if (gap_busy) gap_err <= 1'b1;
              else          st_q    <= S_MARK;
            end
          end
          S_MARK: begin
            if (rx_data == MARK_SECOND) begin
              st_q  <= S_ADDR;
              idx_q <= '0;
            end else if (rx_data != MARK_FIRST) begin
              st_q <= S_HUNT;
            end
          end
          S_ADDR: begin
            addr_q[8*idx_q +: 8] <= rx_data;
            if (idx_q == A_LAST) begin
              st_q   <= S_DATA;
              idx_q  <= '0;
              widx_q <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: begin
            asm_q[8*idx_q +: 8] <= rx_data;
            if (idx_q == D_LAST) begin
              idx_q    <= '0;
              wr_valid <= 1'b1;
              wr_addr  <= addr_q;
              wr_data  <= {rx_data, asm_q[DATA_W-9:0]};
              if (widx_q == words_last) begin
                st_q      <= S_HUNT;
                gap_start <= 1'b1;
              end else begin
                widx_q <= widx_q + 1'b1;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  // R3
  wr_from_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> $past(rx_valid));

  // R6
  gap_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    gap_err |-> ($past(gap_busy) && $past(rx_valid)));
endmodule

// File: rtl/ucf_tx_split.sv
module ucf_tx_split #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  localparam int NB    = DATA_W / 8;
  localparam int CNT_W = $clog2(NB) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NB - 1);

  logic              busy_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign res_ready = !busy_q;
  assign tx_valid  = busy_q;
  assign tx_data   = sh_q[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (res_valid) begin
        busy_q <= 1'b1;
        sh_q   <= res_data;
        cnt_q  <= '0;
      end
    end else if (tx_ready) begin
      sh_q <= sh_q >> 8;
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  tx_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> $past(tx_ready));
endmodule

// File: rtl/ucf_top.sv
module ucf_top #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 4,
  parameter int DIV_W    = 16,
  parameter int GAP_W    = 8,
  parameter int DEF_BITS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [GAP_W-1:0]  gap_bits,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              gap_err,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data
);
  logic gap_start;
  logic gap_busy;

  ucf_gap_timer #(.DIV_W(DIV_W), .GAP_W(GAP_W), .DEF_BITS(DEF_BITS)) u_gap (
    .clk(clk), .rst(rst), .start(gap_start),
    .baud_div(baud_div), .gap_bits(gap_bits), .busy(gap_busy)
  );

  ucf_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .word_count(word_count), .gap_busy(gap_busy), .gap_start(gap_start),
    .gap_err(gap_err), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ucf_tx_split #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data)
  );
endmodule

// File: tb/test_ucf_top.sv
module test_ucf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] baud_div = 16'd4;
  logic [7:0]  gap_bits = 8'd0;
  logic [3:0]  word_count = 4'd1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        gap_err;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [31:0] res_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  int total = 0;
  int fails = 0;
  int cap_n = 0;
  int err_n = 0;
  logic [15:0] cap_a [64];
  logic [31:0] cap_d [64];

  always #10 clk = ~clk;

  ucf_top i_ucf_top (
    .clk(clk), .rst(rst), .baud_div(baud_div), .gap_bits(gap_bits),
    .word_count(word_count), .rx_valid(rx_valid), .rx_data(rx_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .gap_err(gap_err), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
  );

  localparam logic [47:0] VEC [4] = '{
    {16'h1234, 32'h12345678},
    {16'hBEEF, 32'hDEADC0DE},
    {16'h00FF, 32'h55AA55AA},
    {16'h8001, 32'h000000FF}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && wr_ready && cap_n < 64) begin
        cap_a[cap_n] = wr_addr;
        cap_d[cap_n] = wr_data;
        cap_n = cap_n + 1;
      end
      if (gap_err) err_n = err_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) send_byte(w[8*k +: 8]);
  endtask

  task automatic send_head(input logic [15:0] a);
    send_byte(8'h55);
    send_byte(8'hAA);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails = fails + 1;
    total = total + 1;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int base;
    int ebase;
    logic [7:0] got [4];
    int gn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 wr_valid", wr_valid, 0);
    check("R10 tx_valid", tx_valid, 0);
    check("R10 gap_err", gap_err, 0);
    check("R10 res_ready", res_ready, 1);

    // R1 R2 R3 table of single-word frames
    for (int v = 0; v < 4; v++) begin
      base = cap_n;
      send_head(VEC[v][47:32]);
      send_word(VEC[v][31:0]);
      idle(4);
      check("R1 one write per frame", cap_n - base, 1);
      check("R2 address", cap_a[base], VEC[v][47:32]);
      check("R3 data", cap_d[base], VEC[v][31:0]);
      idle(200);
    end

    // R1 no marker, no write
    base = cap_n;
    send_byte(8'hAA); send_byte(8'h12); send_byte(8'h34);
    send_word(32'hCAFEF00D);
    idle(4);
    check("R1 no write without marker", cap_n - base, 0);

    // R5 mismatch then full frame
    base = cap_n;
    send_byte(8'h55); send_byte(8'h12);
    send_byte(8'h34); send_byte(8'h12);
    send_word(32'h11111111);
    idle(4);
    check("R5 mismatch back to hunt", cap_n - base, 0);
    send_byte(8'h55); send_byte(8'h55); send_byte(8'hAA);
    send_byte(8'h21); send_byte(8'h43);
    send_word(32'hA5A5F00F);
    idle(4);
    check("R5 repeated 0x55 restarts count", cap_n - base, 1);
    check("R5 repeated 0x55 restarts data", cap_d[base], 32'hA5A5F00F);
    idle(200);

    // R4 three words, same address
    word_count = 4'd3;
    base = cap_n;
    send_head(16'h4321);
    send_word(32'h01020304);
    send_word(32'hA0B0C0D0);
    send_word(32'hFFFF0000);
    idle(4);
    check("R4 word count", cap_n - base, 3);
    check("R4 word0", cap_d[base], 32'h01020304);
    check("R4 word1", cap_d[base+1], 32'hA0B0C0D0);
    check("R4 word2", cap_d[base+2], 32'hFFFF0000);
    check("R4 address held w1", cap_a[base+1], 16'h4321);
    check("R4 address held w2", cap_a[base+2], 16'h4321);
    idle(200);

    // R4 count 0 behaves as 1
    word_count = 4'd0;
    base = cap_n;
    send_head(16'h0007);
    send_word(32'h76543210);
    idle(4);
    check("R4 zero count gives one word", cap_n - base, 1);
    idle(200);
    word_count = 4'd1;

    // R6 explicit gap 8 bits x 4 ticks = 32 cycles
    gap_bits = 8'd8;
    send_head(16'h0101);
    send_word(32'h0A0B0C0D);
    base = cap_n;
    ebase = err_n;
    idle(10);
    send_head(16'h0202);
    send_word(32'h99999999);
    idle(4);
    check("R6 early marker flagged", err_n - ebase, 1);
    check("R6 early marker ignored", cap_n - base, 0);
    idle(60);
    base = cap_n;
    send_head(16'h0303);
    send_word(32'h33333333);
    idle(4);
    check("R6 marker after gap accepted", cap_n - base, 1);
    check("R6 accepted data", cap_d[base], 32'h33333333);

    // R7 default gap 32 bits x 4 ticks = 128 cycles
    gap_bits = 8'd0;
    idle(200);
    send_head(16'h0404);
    send_word(32'h44444444);
    base = cap_n;
    ebase = err_n;
    idle(90);
    send_byte(8'h55);
    idle(2);
    check("R7 default gap still open", err_n - ebase, 1);
    idle(150);
    send_head(16'h0505);
    send_word(32'h55555555);
    idle(4);
    check("R7 after default gap", cap_n - base, 1);
    check("R7 no extra flag", err_n - ebase, 1);
    idle(200);

    // R8 back-pressure
    wr_ready = 1'b0;
    base = cap_n;
    send_head(16'h0606);
    send_word(32'h66778899);
    idle(6);
    check("R8 valid held", wr_valid, 1);
    check("R8 data held", wr_data, 32'h66778899);
    check("R8 address held", wr_addr, 16'h0606);
    wr_ready = 1'b1;
    idle(3);
    check("R8 one write after release", cap_n - base, 1);
    check("R8 valid dropped", wr_valid, 0);

    // R9 splitter with stalls
    @(negedge clk);
    res_data  = 32'h12345678;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    check("R9 res_ready low while busy", res_ready, 0);
    gn = 0;
    for (int k = 0; k < 16; k++) begin
      tx_ready = (k % 2) == 1;
      if (tx_valid && tx_ready && gn < 4) begin
        got[gn] = tx_data;
        gn = gn + 1;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R9 byte count", gn, 4);
    check("R9 byte0", got[0], 8'h78);
    check("R9 byte1", got[1], 8'h56);
    check("R9 byte2", got[2], 8'h34);
    check("R9 byte3", got[3], 8'h12);
    check("R9 ready again", res_ready, 1);
    check("R9 tx idle", tx_valid, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule